// File: doc/BRIEF.md
# RTC Status Registers and Interrupt Flags

This block holds the four control and status registers of a CMOS-style real-time clock and generates its interrupt. A host tick input arrives with the number of microseconds that have elapsed since the previous tick. The block adds that increment to two accumulators. The first accumulator produces a one-second strobe for an external calendar unit. The second accumulator produces a periodic interrupt at a rate chosen by a 4-bit code. The calendar unit returns its current seconds, minutes and hours. The block compares them with three alarm registers that it holds.

Three interrupt sources exist: update, alarm and periodic. Each is latched in the flag register, and their OR drives a single interrupt output. Software reaches the registers through an index/data port pair. A write to the index port selects a register, and the next access to the data port reads or writes that register. Reading the flag register acknowledges the interrupt and clears it.

Top module: `rtc_stat_irq`

## Requirements
- R1: After reset, control A (index 0x0A) reads 0x26, control B (0x0B) reads 0x06, the flag register (0x0C) reads 0x00, the valid register (0x0D) reads 0x80, and irq_o is low.
- R2: A write to port INDEX_PORT (0x70) loads bits 6:0 of the data into the index. A read strobe on DATA_PORT (0x71) returns the indexed register on io_rdata_o one cycle later, and io_rdata_o holds that value until the next read. The index map is: 0x00/0x02/0x04 are the current seconds/minutes/hours inputs, 0x01/0x03/0x05 are the writable seconds/minutes/hours alarm registers, 0x0A to 0x0D are the control and status registers, and every other index reads 0x00.
- R3: In control A, bits 6:0 are writable and bit 7 always reads 0. Writes to the flag register (0x0C) and to the valid register (0x0D) have no effect.
- R4: Each tick adds tick_us_i to the second accumulator. When the sum is strictly greater than 1000000, the block subtracts 1000000 and sec_strobe_o pulses for one cycle, in the cycle after the tick. If control B bit 7 (update block) is set, the strobe is suppressed, but the accumulator still wraps.
- R5: The periodic source is active when control B bit 6 is set and the rate code in control A bits 3:0 is nonzero. The interval is 1000000 / (65536 >> rate) microseconds, using integer division. On a tick, if the accumulator plus the increment reaches the interval, flag bit 6 is set and the interval is subtracted. While the source is inactive, the accumulator is held at zero.
- R6: When control B bit 4 is set, every tick sets flag bit 4.
- R7: When control B bit 5 is set, the block compares the time inputs with the three alarm registers two cycles after the tick that caused a strobe. If all three bytes are equal, flag bit 5 is set.
- R8: Every tick clears all three source flags before it re-evaluates them, so a flag that the current tick does not raise again reads 0 afterwards.
- R9: Flag bit 7 is the OR of flag bits 4, 5 and 6. irq_o equals flag bit 7, and it rises only after a tick or an alarm match.
- R10: A data-port read of the flag register returns its value before the clear, then clears it. A tick or alarm match in the same cycle wins for the flags it sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_port_i | input | PORT_W | Port address of the access |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, registered |
| tick_i | input | 1 | Elapsed-time tick |
| tick_us_i | input | US_W | Microseconds carried by the tick |
| sec_i | input | 8 | Current seconds from the calendar |
| min_i | input | 8 | Current minutes from the calendar |
| hour_i | input | 8 | Current hours from the calendar |
| sec_strobe_o | output | 1 | One-second strobe to the calendar |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 20-bit increment, 32-bit accumulators and the full one-million-microsecond second. Ticks carry increments of up to 1000001 µs, so a second wrap, the exact-1000000 boundary and the slowest periodic interval (rate 15, 500000 µs) each take only a few ticks. At that rate the alarm match and the strobe suppression also take only a few ticks. A behavioural model of the flag and accumulator arithmetic checks sec_strobe_o, irq_o and io_rdata_o on every clock. Directed sequences check the literal register values.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam logic [6:0] IDX_SEC      = 7'h00;
  localparam logic [6:0] IDX_SEC_ALM  = 7'h01;
  localparam logic [6:0] IDX_MIN      = 7'h02;
  localparam logic [6:0] IDX_MIN_ALM  = 7'h03;
  localparam logic [6:0] IDX_HOUR     = 7'h04;
  localparam logic [6:0] IDX_HOUR_ALM = 7'h05;
  localparam logic [6:0] IDX_CTL_A    = 7'h0A;
  localparam logic [6:0] IDX_CTL_B    = 7'h0B;
  localparam logic [6:0] IDX_FLAGS    = 7'h0C;
  localparam logic [6:0] IDX_VALID    = 7'h0D;

  localparam logic [6:0] CTL_A_RST = 7'h26;
  localparam logic [7:0] CTL_B_RST = 8'h06;
  localparam logic [7:0] VALID_VAL = 8'h80;

  typedef struct packed {
    logic set_blk;
    logic per_en;
    logic alm_en;
    logic upd_en;
    logic sqw;
    logic bcd;
    logic h24;
    logic dst;
  } ctl_b_t;
endpackage

// File: rtl/rtc_sec_accum.sv
module rtc_sec_accum #(
  parameter int US_W   = 20,
  parameter int ACC_W  = 32,
  parameter int SEC_US = 1000000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [US_W-1:0] tick_us_i,
  input  logic            block_i,
  output logic            strobe_o
);
  localparam logic [ACC_W-1:0] SEC_LIM = ACC_W'(SEC_US);

  logic [ACC_W-1:0] acc_q, sum;
  logic             over, strobe_q;

  assign sum  = acc_q + {{(ACC_W-US_W){1'b0}}, tick_us_i};
  assign over = sum > SEC_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (tick_i) acc_q <= over ? sum - SEC_LIM : sum;
      strobe_q <= tick_i && over && !block_i;
    end
  end

  assign strobe_o = strobe_q;

  assert_strobe_after_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(tick_i));
  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !$past(block_i));
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int US_W    = 20,
  parameter int ACC_W   = 32,
  parameter int SEC_US  = 1000000,
  parameter int BASE_HZ = 65536,
  parameter int RATE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [US_W-1:0]   tick_us_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o
);
  localparam int NRATE = 2 ** RATE_W;

  logic [ACC_W-1:0] ivl [NRATE];
  logic [ACC_W-1:0] acc_q, sum, ivl_sel;
  logic             active;

  for (genvar r = 0; r < NRATE; r++) begin : g_ivl
    if (r == 0) begin : g_off
      assign ivl[r] = '0;
    end else begin : g_on
      localparam int unsigned DIV = BASE_HZ >> r;
      localparam int unsigned IVL = (DIV == 0) ? 0 : SEC_US / ((DIV == 0) ? 1 : DIV);
      assign ivl[r] = ACC_W'(IVL);
    end
  end

  assign ivl_sel = ivl[rate_i];
  assign active  = en_i && (ivl_sel != '0);
  assign sum     = acc_q + {{(ACC_W-US_W){1'b0}}, tick_us_i};
  assign hit_o   = tick_i && active && (sum >= ivl_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (!active) acc_q <= '0;
    else if (tick_i)  acc_q <= hit_o ? sum - ivl_sel : sum;
  end

  assert_acc_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> acc_q == '0);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          en_i,
  input  logic [TW-1:0] sec_i,
  input  logic [TW-1:0] min_i,
  input  logic [TW-1:0] hour_i,
  input  logic [TW-1:0] alm_sec_i,
  input  logic [TW-1:0] alm_min_i,
  input  logic [TW-1:0] alm_hour_i,
  output logic          hit_o
);
  logic chk_q, match;

  // Compare one cycle after the strobe, once the calendar has advanced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= strobe_i;
  end

  assign match = (sec_i == alm_sec_i) && (min_i == alm_min_i) && (hour_i == alm_hour_i);
  assign hit_o = chk_q && en_i && match;

  assert_alarm_after_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(strobe_i));
endmodule

// File: rtl/rtc_stat_irq.sv
module rtc_stat_irq
  import rtc_stat_pkg::*;
#(
  parameter int          US_W       = 20,
  parameter int          ACC_W      = 32,
  parameter int          SEC_US     = 1000000,
  parameter int          BASE_HZ    = 65536,
  parameter int          PORT_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h0070,
  parameter logic [15:0] DATA_PORT  = 16'h0071
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              tick_i,
  input  logic [US_W-1:0]   tick_us_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  output logic              sec_strobe_o,
  output logic              irq_o
);
  localparam logic [PORT_W-1:0] IDX_P = PORT_W'(INDEX_PORT);
  localparam logic [PORT_W-1:0] DAT_P = PORT_W'(DATA_PORT);

  logic [6:0] idx_q, ctl_a_q;
  ctl_b_t     ctl_b_q;
  logic [7:0] alm_s_q, alm_m_q, alm_h_q, rdata_q, rd_mux, flags_byte;
  logic       pf_q, af_q, uf_q;
  logic       idx_wr, dat_wr, dat_rd, rd_flags;
  logic       per_hit, alm_hit;
  logic       pf_d, af_d, uf_d;

  assign idx_wr   = io_wr_i && (io_port_i == IDX_P);
  assign dat_wr   = io_wr_i && (io_port_i == DAT_P);
  assign dat_rd   = io_rd_i && (io_port_i == DAT_P);
  assign rd_flags = dat_rd && (idx_q == IDX_FLAGS);

  rtc_sec_accum #(.US_W(US_W), .ACC_W(ACC_W), .SEC_US(SEC_US)) i_sec_accum (
    .clk_i, .rst_ni, .tick_i, .tick_us_i,
    .block_i  (ctl_b_q.set_blk),
    .strobe_o (sec_strobe_o)
  );

  rtc_periodic #(.US_W(US_W), .ACC_W(ACC_W), .SEC_US(SEC_US), .BASE_HZ(BASE_HZ), .RATE_W(4))
  i_periodic (
    .clk_i, .rst_ni, .tick_i, .tick_us_i,
    .en_i   (ctl_b_q.per_en),
    .rate_i (ctl_a_q[3:0]),
    .hit_o  (per_hit)
  );

  rtc_alarm_cmp #(.TW(8)) i_alarm (
    .clk_i, .rst_ni,
    .strobe_i   (sec_strobe_o),
    .en_i       (ctl_b_q.alm_en),
    .sec_i, .min_i, .hour_i,
    .alm_sec_i  (alm_s_q),
    .alm_min_i  (alm_m_q),
    .alm_hour_i (alm_h_q),
    .hit_o      (alm_hit)
  );

  // Tick clears and re-evaluates; events beat a same-cycle acknowledge
  assign uf_d = tick_i ? ctl_b_q.upd_en : (uf_q && !rd_flags);
  assign pf_d = tick_i ? per_hit        : (pf_q && !rd_flags);
  assign af_d = alm_hit || (af_q && !tick_i && !rd_flags);

  assign irq_o      = pf_q || af_q || uf_q;
  assign flags_byte = {irq_o, pf_q, af_q, uf_q, 4'b0000};

  always_comb begin
    unique case (idx_q)
      IDX_SEC:      rd_mux = sec_i;
      IDX_SEC_ALM:  rd_mux = alm_s_q;
      IDX_MIN:      rd_mux = min_i;
      IDX_MIN_ALM:  rd_mux = alm_m_q;
      IDX_HOUR:     rd_mux = hour_i;
      IDX_HOUR_ALM: rd_mux = alm_h_q;
      IDX_CTL_A:    rd_mux = {1'b0, ctl_a_q};
      IDX_CTL_B:    rd_mux = ctl_b_q;
      IDX_FLAGS:    rd_mux = flags_byte;
      IDX_VALID:    rd_mux = VALID_VAL;
      default:      rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      ctl_a_q <= CTL_A_RST;
      ctl_b_q <= CTL_B_RST;
      alm_s_q <= '0;
      alm_m_q <= '0;
      alm_h_q <= '0;
      rdata_q <= '0;
      pf_q    <= 1'b0;
      af_q    <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      pf_q <= pf_d;
      af_q <= af_d;
      uf_q <= uf_d;
      if (dat_rd) rdata_q <= rd_mux;
      if (idx_wr) idx_q <= io_wdata_i[6:0];
      if (dat_wr) begin
        case (idx_q)
          IDX_SEC_ALM:  alm_s_q <= io_wdata_i;
          IDX_MIN_ALM:  alm_m_q <= io_wdata_i;
          IDX_HOUR_ALM: alm_h_q <= io_wdata_i;
          IDX_CTL_A:    ctl_a_q <= io_wdata_i[6:0];
          IDX_CTL_B:    ctl_b_q <= io_wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign io_rdata_o = rdata_q;

  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_flags && !tick_i && !alm_hit) |=> !irq_o);
  assert_tick_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !per_hit && !ctl_b_q.upd_en && !alm_hit) |=> !irq_o);
  assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(tick_i) || $past(alm_hit)));
  assert_flag_wr_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && idx_q == IDX_FLAGS && !irq_o && !tick_i && !alm_hit) |=> !irq_o);
endmodule

// File: tb/test_rtc_stat_irq.sv
module test_rtc_stat_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_port = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        tick = 1'b0;
  logic [19:0] tick_us = '0;
  logic [7:0]  cal_s, cal_m, cal_h;
  logic [7:0]  set_s = '0, set_m = '0, set_h = '0;
  logic        cal_load = 1'b0;
  logic        sec_strobe, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_stat_irq i_rtc_stat_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .io_port_i(io_port), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .tick_i(tick), .tick_us_i(tick_us),
    .sec_i(cal_s), .min_i(cal_m), .hour_i(cal_h),
    .sec_strobe_o(sec_strobe), .irq_o(irq)
  );

  // Calendar stand-in
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_s <= '0; cal_m <= '0; cal_h <= '0;
    end else if (cal_load) begin
      cal_s <= set_s; cal_m <= set_m; cal_h <= set_h;
    end else if (sec_strobe) begin
      if (cal_s == 59) begin
        cal_s <= 0;
        if (cal_m == 59) begin cal_m <= 0; cal_h <= (cal_h == 23) ? 8'd0 : cal_h + 1; end
        else cal_m <= cal_m + 1;
      end else cal_s <= cal_s + 1;
    end
  end

  // Reference model
  int     m_idx, m_a, m_b, m_as, m_am, m_ah, m_rdata;
  bit     m_pf, m_af, m_uf, m_strobe, m_chk;
  longint m_acc_s, m_acc_p, m_sum, m_iv;
  int     m_rate;
  bit     m_en, m_rdc, m_ph, m_ah_hit, m_news;

  function automatic int mval(int i);
    case (i)
      0: return int'(cal_s);
      1: return m_as;
      2: return int'(cal_m);
      3: return m_am;
      4: return int'(cal_h);
      5: return m_ah;
      10: return m_a;
      11: return m_b;
      12: return ((m_pf | m_af | m_uf) << 7) | (m_pf << 6) | (m_af << 5) | (m_uf << 4);
      13: return 'h80;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_a = 'h26; m_b = 'h06; m_as = 0; m_am = 0; m_ah = 0; m_rdata = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_strobe = 0; m_chk = 0; m_acc_s = 0; m_acc_p = 0;
    end else begin
      m_rdc    = io_rd && io_port == 16'h71 && m_idx == 12;
      m_rate   = m_a & 15;
      m_en     = m_b[6] && m_rate != 0;
      m_news   = 0;
      m_ph     = 0;
      m_ah_hit = m_chk && m_b[5] && int'(cal_s) == m_as && int'(cal_m) == m_am && int'(cal_h) == m_ah;
      if (io_rd && io_port == 16'h71) m_rdata = mval(m_idx);
      if (tick) begin
        m_sum = m_acc_s + tick_us;
        if (m_sum > 1000000) begin m_sum -= 1000000; m_news = !m_b[7]; end
        m_acc_s = m_sum;
      end
      if (!m_en) m_acc_p = 0;
      else if (tick) begin
        m_sum = m_acc_p + tick_us;
        m_iv  = 1000000 / (65536 >> m_rate);
        if (m_sum >= m_iv) begin m_ph = 1; m_sum -= m_iv; end
        m_acc_p = m_sum;
      end
      m_uf = tick ? m_b[4] : (m_uf && !m_rdc);
      m_pf = tick ? m_ph : (m_pf && !m_rdc);
      m_af = m_ah_hit || (m_af && !tick && !m_rdc);
      if (io_wr && io_port == 16'h70) m_idx = io_wdata & 127;
      else if (io_wr && io_port == 16'h71) begin
        case (m_idx)
          1: m_as = io_wdata;
          3: m_am = io_wdata;
          5: m_ah = io_wdata;
          10: m_a = io_wdata & 127;
          11: m_b = io_wdata;
          default: ;
        endcase
      end
      m_chk    = m_strobe;
      m_strobe = m_news;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 irq_o vs model", {31'd0, irq}, {31'd0, m_pf | m_af | m_uf});
      chk("R4 sec_strobe_o vs model", {31'd0, sec_strobe}, {31'd0, m_strobe});
      chk("R2 io_rdata_o vs model", {24'd0, io_rdata}, m_rdata[31:0]);
    end
  end

  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    io_port = p; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [6:0] idx, input logic [7:0] d);
    io_write(16'h70, {1'b0, idx});
    io_write(16'h71, d);
  endtask

  task automatic reg_read(input logic [6:0] idx, output logic [7:0] v);
    io_write(16'h70, {1'b0, idx});
    io_port = 16'h71; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic do_tick(input int us);
    tick = 1'b1; tick_us = 20'(us);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic cal_set(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    set_h = h; set_m = m; set_s = s; cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 0);
    reg_read(7'h0A, v); chk("R1 ctl A reset", v, 'h26);
    reg_read(7'h0B, v); chk("R1 ctl B reset", v, 'h06);
    reg_read(7'h0C, v); chk("R1 flags reset", v, 'h00);
    reg_read(7'h0D, v); chk("R1 valid reset", v, 'h80);

    // R2 index/data access
    cal_set(8'd3, 8'd5, 8'd10);
    reg_write(7'h01, 8'h2A); reg_read(7'h01, v); chk("R2 alarm sec readback", v, 'h2A);
    reg_read(7'h00, v); chk("R2 seconds input", v, 8'd10);
    reg_read(7'h04, v); chk("R2 hours input", v, 8'd3);
    reg_read(7'h20, v); chk("R2 unmapped index", v, 'h00);

    // R3 write masks
    reg_write(7'h0A, 8'hFF); reg_read(7'h0A, v); chk("R3 ctl A bit7 reads 0", v, 'h7F);
    reg_write(7'h0C, 8'hFF); reg_read(7'h0C, v); chk("R3 flags write ignored", v, 'h00);
    chk("R3 irq after flags write", {31'd0, irq}, 0);
    reg_write(7'h0D, 8'h00); reg_read(7'h0D, v); chk("R3 valid write ignored", v, 'h80);
    reg_write(7'h0A, 8'h26);

    // R4 second accumulator
    for (int i = 0; i < 3; i++) begin
      do_tick(300000); chk("R4 no strobe below second", {31'd0, sec_strobe}, 0);
    end
    do_tick(300000); chk("R4 strobe on wrap", {31'd0, sec_strobe}, 1);
    @(negedge clk); chk("R4 strobe one cycle", {31'd0, sec_strobe}, 0);
    reg_write(7'h0B, 8'h86);
    do_tick(900000); chk("R4 strobe blocked", {31'd0, sec_strobe}, 0);
    reg_write(7'h0B, 8'h06);
    do_tick(900000); chk("R4 exactly one second no strobe", {31'd0, sec_strobe}, 0);
    do_tick(1); chk("R4 strobe after exceed", {31'd0, sec_strobe}, 1);

    // R5 periodic
    reg_write(7'h0B, 8'h46);
    do_tick(500); chk("R5 below interval", {31'd0, irq}, 0);
    do_tick(500); chk("R5 periodic at 976us", {31'd0, irq}, 1);
    reg_read(7'h0C, v); chk("R5 flags periodic", v, 'hC0);
    chk("R10 irq after ack", {31'd0, irq}, 0);
    reg_write(7'h0A, 8'h2F);
    do_tick(499975); chk("R5 rate15 one short", {31'd0, irq}, 0);
    do_tick(1); chk("R5 rate15 reaches 500000", {31'd0, irq}, 1);
    reg_read(7'h0C, v); chk("R9 flags periodic OR", v, 'hC0);
    reg_write(7'h0A, 8'h20);
    do_tick(600000); do_tick(600000);
    reg_read(7'h0C, v); chk("R5 rate 0 disabled", v, 'h00);
    reg_write(7'h0A, 8'h26);

    // R6 / R8 update flag
    reg_write(7'h0B, 8'h16);
    do_tick(10); chk("R6 update irq", {31'd0, irq}, 1);
    reg_read(7'h0C, v); chk("R6 flags update", v, 'h90);
    do_tick(10);
    reg_write(7'h0B, 8'h06);
    do_tick(10); chk("R8 tick clears update flag", {31'd0, irq}, 0);
    reg_read(7'h0C, v); chk("R8 flags cleared", v, 'h00);

    // R10 acknowledge races a tick
    reg_write(7'h0B, 8'h16);
    do_tick(10);
    io_write(16'h70, 8'h0C);
    io_port = 16'h71; io_rd = 1'b1; tick = 1'b1; tick_us = 20'd10;
    @(negedge clk);
    io_rd = 1'b0; tick = 1'b0;
    chk("R10 read returns pre-clear", io_rdata, 'h90);
    reg_read(7'h0C, v); chk("R10 tick wins over ack", v, 'h90);
    reg_read(7'h0C, v); chk("R10 second ack clears", v, 'h00);

    // R7 alarm
    reg_write(7'h0B, 8'h26);
    reg_write(7'h01, 8'd11); reg_write(7'h03, 8'd5); reg_write(7'h05, 8'd3);
    cal_set(8'd3, 8'd5, 8'd10);
    do_tick(1000001);
    repeat (2) @(negedge clk);
    chk("R7 alarm irq", {31'd0, irq}, 1);
    reg_read(7'h0C, v); chk("R7 flags alarm", v, 'hA0);
    do_tick(1000001);
    repeat (2) @(negedge clk);
    chk("R7 no match no alarm", {31'd0, irq}, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule